// File: doc/BRIEF.md
# SCL Clock Divider Generator

This block produces the serial clock waveform for a two-wire bus master from the system clock. A prescaler divides the system clock into module-clock ticks. Each SCL period is then built from a low phase and a high phase. Each phase lasts for its programmed count plus a fixed extra number of ticks. That extra number depends only on the prescaler value: 7 ticks when the prescaler is 0, 6 when it is 1, and 5 when it is 2 or more. A one-cycle strobe marks the first cycle of each phase. A byte engine uses these strobes to shift a data bit while SCL is low and to sample it while SCL is high.

Software loads the three 16-bit values (prescaler, low count, high count) while the module enable is low. It then raises the enable. It chooses the prescaler so that the module clock falls in roughly the 7 to 12 MHz range. While enabled, a run request starts the periods and keeps them coming. The block captures the three values at the start of every SCL period, so a change made mid-period never alters a phase already in progress. Clearing the run request lets the current period finish. Clearing the enable stops the waveform at once. There is no data path, so every pin is a plain level or pulse without a handshake.

Top module: `scl_timing_gen`

## Requirements
- R1: While rst_n is low, scl is 1 and both strobes are 0.
- R2: With mod_en high and run low in the idle state, scl stays 1 and neither strobe fires.
- R3: A run request seen at a clock edge while idle and enabled drives scl to 0, with low_start at 1, in the cycle that follows that edge.
- R4: The low phase lasts (low_cnt + d) * (prescale + 1) system-clock cycles. This is measured from the low_start cycle to the high_start cycle.
- R5: The high phase lasts (high_cnt + d) * (prescale + 1) system-clock cycles. This is measured from the high_start cycle to the next low_start cycle.
- R6: The offset d is 7 for prescale 0, 6 for prescale 1, and 5 for any prescale of 2 or more.
- R7: low_start and high_start are single-cycle pulses and never fire together. low_start fires only in the first cycle with scl at 0, and high_start only in the first cycle with scl at 1.
- R8: Values on prescale, low_cnt and high_cnt are captured only when a period starts. A change made during a period first affects the next period.
- R9: When run is low at the end of a high phase, the block returns to idle with scl at 1. A period already under way always completes both of its phases.
- R10: Driving mod_en low forces scl to 1 and clears the strobes in the following cycle, whatever the phase. After that, enable plus run starts a fresh period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; low holds the generator stopped with scl high |
| prescale | input | 16 | Prescaler value; the module clock is clk / (prescale + 1) |
| low_cnt | input | 16 | Programmed low-phase count in module-clock ticks |
| high_cnt | input | 16 | Programmed high-phase count in module-clock ticks |
| run | input | 1 | Request to keep generating SCL periods |
| scl | output | 1 | SCL level |
| low_start | output | 1 | One-cycle pulse in the first cycle of each low phase |
| high_start | output | 1 | One-cycle pulse in the first cycle of each high phase |

## Verification
All outputs come from registers. A run request or a drop of the enable, applied between edges, shows up at the outputs one clock edge later. The bench therefore drives on the falling edge and checks the level at the next falling edge.

Phase lengths are due after (count + d) * (prescale + 1) cycles. The bench counts falling edges from one strobe to the next and compares the count with a bench function built only from that formula and the d table.

For register changes made mid-period, the expected lengths come from the old values for the rest of that period and from the new values for the period after it.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  // Per-phase extra ticks selected by the prescaler value
  localparam int OFF_W      = 3;
  localparam int OFF_PSC0   = 7;
  localparam int OFF_PSC1   = 6;
  localparam int OFF_PSCN   = 5;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] psc,
  output logic             tick
);
  logic [CNT_W-1:0] div_q;

  // One tick every psc+1 cycles while a period is running
  assign tick = active && (div_q == psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!active || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
  import scl_div_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] psc_in,
  input  logic [CNT_W-1:0] low_in,
  input  logic [CNT_W-1:0] high_in,
  output logic [CNT_W-1:0] psc_q,
  output logic [LEN_W-1:0] low_len_q,
  output logic [LEN_W-1:0] high_len_q
);
  logic [OFF_W-1:0] extra;
  logic [LEN_W-1:0] low_len_d;
  logic [LEN_W-1:0] high_len_d;

  always_comb begin
    if (psc_in == '0) begin
      extra = OFF_W'(OFF_PSC0);
    end else if (psc_in == CNT_W'(1)) begin
      extra = OFF_W'(OFF_PSC1);
    end else begin
      extra = OFF_W'(OFF_PSCN);
    end
  end

  assign low_len_d  = LEN_W'(low_in)  + LEN_W'(extra);
  assign high_len_d = LEN_W'(high_in) + LEN_W'(extra);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q      <= '0;
      low_len_q  <= LEN_W'(OFF_PSC0);
      high_len_q <= LEN_W'(OFF_PSC0);
    end else if (load) begin
      psc_q      <= psc_in;
      low_len_q  <= low_len_d;
      high_len_q <= high_len_d;
    end
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_div_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic             tick,
  input  logic [LEN_W-1:0] low_len,
  input  logic [LEN_W-1:0] high_len,
  output logic             start_period,
  output logic             active,
  output logic             scl,
  output logic             low_start,
  output logic             high_start
);
  phase_e           ph_q;
  logic [LEN_W-1:0] tick_cnt_q;
  logic [LEN_W-1:0] cur_len;
  logic             phase_last;

  assign cur_len      = (ph_q == PH_LOW) ? low_len : high_len;
  assign phase_last   = tick && (tick_cnt_q == cur_len - 1'b1);
  assign active       = (ph_q != PH_IDLE);
  assign start_period = en && run &&
                        ((ph_q == PH_IDLE) || ((ph_q == PH_HIGH) && phase_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      tick_cnt_q <= '0;
      scl        <= 1'b1;
      low_start  <= 1'b0;
      high_start <= 1'b0;
    end else if (!en) begin
      ph_q       <= PH_IDLE;
      tick_cnt_q <= '0;
      scl        <= 1'b1;
      low_start  <= 1'b0;
      high_start <= 1'b0;
    end else begin
      low_start  <= 1'b0;
      high_start <= 1'b0;
      case (ph_q)
        PH_IDLE: begin
          if (run) begin
            ph_q       <= PH_LOW;
            scl        <= 1'b0;
            low_start  <= 1'b1;
            tick_cnt_q <= '0;
          end
        end
        PH_LOW: begin
          if (phase_last) begin
            ph_q       <= PH_HIGH;
            scl        <= 1'b1;
            high_start <= 1'b1;
            tick_cnt_q <= '0;
          end else if (tick) begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (phase_last) begin
            tick_cnt_q <= '0;
            if (run) begin
              ph_q      <= PH_LOW;
              scl       <= 1'b0;
              low_start <= 1'b1;
            end else begin
              ph_q <= PH_IDLE;
            end
          end else if (tick) begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
          end
        end
        default: begin
          ph_q <= PH_IDLE;
          scl  <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic [CNT_W-1:0] prescale,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             run,
  output logic             scl,
  output logic             low_start,
  output logic             high_start
);
  localparam int LEN_W = CNT_W + 1;

  logic             tick;
  logic             active;
  logic             start_period;
  logic [CNT_W-1:0] psc_q;
  logic [LEN_W-1:0] low_len_q;
  logic [LEN_W-1:0] high_len_q;

  scl_cfg_latch #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_period),
    .psc_in     (prescale),
    .low_in     (low_cnt),
    .high_in    (high_cnt),
    .psc_q      (psc_q),
    .low_len_q  (low_len_q),
    .high_len_q (high_len_q)
  );

  scl_prescaler #(.CNT_W(CNT_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .psc    (psc_q),
    .tick   (tick)
  );

  scl_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (mod_en),
    .run          (run),
    .tick         (tick),
    .low_len      (low_len_q),
    .high_len     (high_len_q),
    .start_period (start_period),
    .active       (active),
    .scl          (scl),
    .low_start    (low_start),
    .high_start   (high_start)
  );
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk #(
  parameter int LEN_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             scl,
  input logic             low_start,
  input logic             high_start,
  input logic [LEN_W-1:0] low_len,
  input logic [LEN_W-1:0] high_len
);
  // R10
  disabled_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl && !low_start && !high_start));

  // R7
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_start, high_start}));

  // R7
  low_strobe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_start |-> !scl);

  // R7
  high_strobe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    high_start |-> scl);

  // R7
  low_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_start |=> !low_start);

  // R3
  scl_fall_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl) |-> low_start);

  // R8
  cfg_change_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(low_len) || !$stable(high_len)) |-> low_start);
endmodule

bind scl_timing_gen scl_timing_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (mod_en),
  .scl        (scl),
  .low_start  (low_start),
  .high_start (high_start),
  .low_len    (low_len_q),
  .high_len   (high_len_q)
);

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b0;
  logic [15:0] prescale = '0;
  logic [15:0] low_cnt = '0;
  logic [15:0] high_cnt = '0;
  logic        run = 1'b0;
  logic        scl, low_start, high_start;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  scl_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .prescale(prescale),
    .low_cnt(low_cnt), .high_cnt(high_cnt), .run(run),
    .scl(scl), .low_start(low_start), .high_start(high_start)
  );

  function automatic int off_of(input int psc);  // R6
    if (psc == 0) return 7;
    if (psc == 1) return 6;
    return 5;
  endfunction

  function automatic int phase_len(input int cnt, input int psc);
    return (cnt + off_of(psc)) * (psc + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_to(input bit want_high, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(want_high ? high_start : low_start) && n < 50000);
  endtask

  task automatic load_cfg(input int psc, input int lo, input int hi);
    @(negedge clk);
    mod_en = 1'b0; run = 1'b0;
    @(negedge clk);
    prescale = 16'(psc); low_cnt = 16'(lo); high_cnt = 16'(hi);
    @(negedge clk);
    mod_en = 1'b1;
  endtask

  // Start, check R3, measure one full period (R4, R5, R6), stop
  task automatic one_period(input int psc, input int lo, input int hi, input string tag);
    int n;
    load_cfg(psc, lo, hi);
    run = 1'b1;
    @(negedge clk);
    check(low_start && !scl, {"R3 start ", tag}, int'(low_start), 1);
    count_to(1'b1, n);
    check(n == phase_len(lo, psc), {"R4 R6 low ", tag}, n, phase_len(lo, psc));
    count_to(1'b0, n);
    check(n == phase_len(hi, psc), {"R5 R6 high ", tag}, n, phase_len(hi, psc));
    mod_en = 1'b0; run = 1'b0;
  endtask

  initial begin
    int n;
    int bad;
    void'($urandom(32'h5C1D_0042));
    mod_en = 1'b1; run = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(scl && !low_start && !high_start, "R1 reset", int'(scl), 1);
    run = 1'b0;
    rst_n = 1'b1;

    // R2: enabled but no run request
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!scl || low_start || high_start) bad++;
    end
    check(bad == 0, "R2 idle", bad, 0);

    // Directed: prescaler 0, 1, 2, 3 and minimum counts
    one_period(0, 10, 8, "psc0");
    one_period(1, 10, 8, "psc1");
    one_period(2, 10, 8, "psc2");
    one_period(3, 10, 8, "psc3");
    one_period(0, 0, 0, "zero counts");

    // Random configurations
    for (int t = 0; t < 12; t++) begin
      one_period(int'($urandom_range(0, 5)), int'($urandom_range(0, 20)),
                 int'($urandom_range(0, 20)), "random");
    end

    // R8: change registers mid-period
    load_cfg(1, 4, 3);
    run = 1'b1;
    @(negedge clk);
    prescale = 16'd0; low_cnt = 16'd9; high_cnt = 16'd2;
    count_to(1'b1, n);
    check(n == phase_len(4, 1), "R8 old low", n, phase_len(4, 1));
    count_to(1'b0, n);
    check(n == phase_len(3, 1), "R8 old high", n, phase_len(3, 1));
    count_to(1'b1, n);
    check(n == phase_len(9, 0), "R8 new low", n, phase_len(9, 0));
    count_to(1'b0, n);
    check(n == phase_len(2, 0), "R8 new high", n, phase_len(2, 0));

    // R9: drop run during low phase; period completes then idles
    load_cfg(1, 3, 5);
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    count_to(1'b1, n);
    check(n == phase_len(3, 1), "R9 low completes", n, phase_len(3, 1));
    bad = 0;
    for (int i = 0; i < phase_len(5, 1) * 3; i++) begin
      @(negedge clk);
      if (low_start) bad++;
    end
    check(bad == 0 && scl, "R9 idle after period", bad, 0);

    // R10: drop enable mid low phase, then restart
    load_cfg(0, 20, 20);
    run = 1'b1;
    repeat (4) @(negedge clk);
    mod_en = 1'b0;
    @(negedge clk);
    check(scl && !low_start && !high_start, "R10 forced high", int'(scl), 1);
    mod_en = 1'b1;
    @(negedge clk);
    check(low_start && !scl, "R10 fresh start", int'(low_start), 1);
    count_to(1'b1, n);
    check(n == phase_len(20, 0), "R10 full low after restart", n, phase_len(20, 0));
    mod_en = 1'b0; run = 1'b0;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule